// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style core that executes fixed 12-bit instruction words. Each cycle it decodes the current instruction, takes the working register as its first operand and a second operand that is either the addressed general-purpose register, the addressed special register or an 8-bit immediate, and returns a result byte. For every instruction it states where the result goes (working register or addressed file register) and which of the zero, carry and digit-carry flags take new values.

The three flags live in a small register inside the block. The carry flag feeds back as the carry-in of the add, subtract and rotate operations. The next value of each flag and its load enable are also exposed, so the surrounding core can mirror the flags into a memory-mapped status register. Instruction fetch, the register file and the program counter are outside the block.

A parameter picks how the adder uses the carry flag. With the chained variant, add and subtract consume the stored carry. With the plain variant, add uses no carry and subtract uses no borrow.

Top module: `acc_alu`

## Requirements
- R1: Operand B is `ram_data` when `sfr_sel`=0 and `sfr_data` when `sfr_sel`=1; literal forms replace it with the immediate `instr[7:0]`.
- R2: Byte forms (`instr[11:10]`=00, opcode `instr[11:6]`) route by `instr[5]`: 0 raises `w_load`, 1 raises `f_load`; the two are never high together.
- R3: Opcode 000111 adds: result = W + B + C. `c_next` is the carry out of bit 7, `dc_next` the carry out of bit 3 and `z_next` is set for a zero result. All three loads are high.
- R4: Opcode 000010 subtracts: result = B + ~W + C, i.e. B − W with borrow = !C. `c_next`=1 means no borrow out of bit 7 and `dc_next`=1 means no borrow out of bit 3. All three loads are high.
- R5: The following opcodes load only Z, with `z_next` = (result == 0): 000011 gives B−1, 000100 gives W|B, 000101 gives W&B, 000110 gives W^B, 001000 gives B, 001001 gives ~B, and 001010 gives B+1.
- R6: Opcode 001100 gives {C, B[7:1]} with `c_next`=B[0]. Opcode 001101 gives {B[6:0], C} with `c_next`=B[7]. Only `c_load` is high for both.
- R7: Opcodes 001110 (nibble swap of B), 001011 (B−1) and 001111 (B+1) write as in R2 and load no flag.
- R8: `instr[11:8]`=0100 clears and 0101 sets bit `instr[7:5]` of B. The result goes to the file register with no flag load.
- R9: Literal forms write only the working register. `instr[11:8]`=1100 and 1000 give the immediate with no flag load. 1101, 1110 and 1111 give W OR, AND or XOR the immediate and load Z only.
- R10: `instr[11:5]`=0000001 gives W with `f_load` and no flags. Opcode 000001 gives 0, with `z_next`=1, `z_load` high and the destination set as in R2.
- R11: The forms `instr[11:5]`=0000000 (no-op and special), `instr[11:9]`=011 (bit tests), `instr[11:8]`=1001 and `instr[11:9]`=101 raise no write enable and no flag load.
- R12: An active-low asynchronous reset clears `z_flag`, `c_flag` and `dc_flag`. On each rising clock edge a flag takes its next value if its load is high and holds otherwise.
- R13: With `CARRY_CHAIN`=1, `c_flag` is the carry-in for add, subtract and rotate. With `CARRY_CHAIN`=0, add uses carry-in 0 and subtract uses carry-in 1, while rotates still use `c_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| instr | input | 12 | Current instruction word |
| w_data | input | 8 | Working register value (operand A) |
| ram_data | input | 8 | Addressed general-purpose register value |
| sfr_data | input | 8 | Addressed special register value |
| sfr_sel | input | 1 | Operand B source: 0 general register, 1 special register |
| result | output | 8 | Result byte |
| z_next | output | 1 | Zero flag value for this instruction |
| c_next | output | 1 | Carry flag value for this instruction |
| dc_next | output | 1 | Digit-carry flag value for this instruction |
| z_load | output | 1 | Zero flag update enable |
| c_load | output | 1 | Carry flag update enable |
| dc_load | output | 1 | Digit-carry flag update enable |
| w_load | output | 1 | Write result to working register |
| f_load | output | 1 | Write result to addressed file register |
| z_flag | output | 1 | Stored zero flag |
| c_flag | output | 1 | Stored carry flag |
| dc_flag | output | 1 | Stored digit-carry flag |

## Verification
The bench builds the block with `DATA_W`=8 and `CARRY_CHAIN`=1. With these values the immediate fills the whole operand and the nibble boundary sits at bit 3. The stored carry also reaches the adder, so each arithmetic vector is run after forcing C to a chosen value with a rotate. This exposes carry-in and borrow-in effects in the result, the carry out and the digit-carry out, including wrap to zero, borrow across the nibble boundary and an add that overflows only because the carry-in is set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_NONE,
      OP_PASS_W,
      OP_PASS_B,
      OP_CLR,
      OP_ADD,
      OP_SUB,
      OP_INC,
      OP_DEC,
      OP_AND,
      OP_OR,
      OP_XOR,
      OP_COM,
      OP_RL,
      OP_RR,
      OP_SWAP,
      OP_BCLR,
      OP_BSET
   } alu_op_e;

   typedef struct packed {
      alu_op_e op;
      logic    use_lit;
      logic    wr_w;
      logic    wr_f;
      logic    ld_z;
      logic    ld_c;
      logic    ld_dc;
   } dec_t;

   localparam int NFLAG = 3;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [6:0] fld,
   output dec_t       dec
);

   logic [1:0] grp;
   logic [3:0] sub;
   logic       dst;

   assign grp = fld[6:5];
   assign sub = fld[4:1];
   assign dst = fld[0];

   always_comb begin
      dec.op      = OP_NONE;
      dec.use_lit = 1'b0;
      dec.wr_w    = 1'b0;
      dec.wr_f    = 1'b0;
      dec.ld_z    = 1'b0;
      dec.ld_c    = 1'b0;
      dec.ld_dc   = 1'b0;
      case (grp)
         2'b00: begin
            dec.wr_w = !dst;
            dec.wr_f = dst;
            case (sub)
               4'h0: begin
                  dec.op   = OP_PASS_W;
                  dec.wr_w = 1'b0;
               end
               4'h1: begin dec.op = OP_CLR;    dec.ld_z = 1'b1; end
               4'h2: begin
                  dec.op    = OP_SUB;
                  dec.ld_z  = 1'b1;
                  dec.ld_c  = 1'b1;
                  dec.ld_dc = 1'b1;
               end
               4'h3: begin dec.op = OP_DEC;    dec.ld_z = 1'b1; end
               4'h4: begin dec.op = OP_OR;     dec.ld_z = 1'b1; end
               4'h5: begin dec.op = OP_AND;    dec.ld_z = 1'b1; end
               4'h6: begin dec.op = OP_XOR;    dec.ld_z = 1'b1; end
               4'h7: begin
                  dec.op    = OP_ADD;
                  dec.ld_z  = 1'b1;
                  dec.ld_c  = 1'b1;
                  dec.ld_dc = 1'b1;
               end
               4'h8: begin dec.op = OP_PASS_B; dec.ld_z = 1'b1; end
               4'h9: begin dec.op = OP_COM;    dec.ld_z = 1'b1; end
               4'hA: begin dec.op = OP_INC;    dec.ld_z = 1'b1; end
               4'hB: dec.op = OP_DEC;
               4'hC: begin dec.op = OP_RR;     dec.ld_c = 1'b1; end
               4'hD: begin dec.op = OP_RL;     dec.ld_c = 1'b1; end
               4'hE: dec.op = OP_SWAP;
               default: dec.op = OP_INC;
            endcase
         end
         2'b01: begin
            if (!sub[3]) begin
               dec.op   = sub[2] ? OP_BSET : OP_BCLR;
               dec.wr_f = 1'b1;
            end
         end
         2'b10: begin
            if (sub[3:2] == 2'b00) begin
               dec.op      = OP_PASS_B;
               dec.use_lit = 1'b1;
               dec.wr_w    = 1'b1;
            end
         end
         default: begin
            dec.use_lit = 1'b1;
            dec.wr_w    = 1'b1;
            case (sub[3:2])
               2'b00:   dec.op = OP_PASS_B;
               2'b01:   begin dec.op = OP_OR;  dec.ld_z = 1'b1; end
               2'b10:   begin dec.op = OP_AND; dec.ld_z = 1'b1; end
               default: begin dec.op = OP_XOR; dec.ld_z = 1'b1; end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit CARRY_CHAIN = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic [2:0]        bit_idx,
   output logic [DATA_W-1:0] res,
   output logic              z,
   output logic              c,
   output logic              dc
);

   localparam int HALF = DATA_W / 2;

   logic add_ci;
   logic sub_ci;

   generate
      if (CARRY_CHAIN) begin : g_chain
         assign add_ci = cin;
         assign sub_ci = cin;
      end else begin : g_plain
         assign add_ci = 1'b0;
         assign sub_ci = 1'b1;
      end
   endgenerate

   logic              is_sub;
   logic [DATA_W-1:0] x;
   logic              ci;
   logic [DATA_W:0]   full;
   logic [HALF:0]     half;
   logic [DATA_W-1:0] mask;

   always_comb begin
      is_sub = (op == OP_SUB);
      x      = is_sub ? ~a : a;
      ci     = is_sub ? sub_ci : add_ci;
      full   = {1'b0, b} + {1'b0, x} + {{DATA_W{1'b0}}, ci};
      half   = {1'b0, b[HALF-1:0]} + {1'b0, x[HALF-1:0]} + {{HALF{1'b0}}, ci};
      mask   = DATA_W'(1) << bit_idx;
   end

   always_comb begin
      res = '0;
      c   = cin;
      dc  = 1'b0;
      case (op)
         OP_PASS_W: res = a;
         OP_PASS_B: res = b;
         OP_CLR:    res = '0;
         OP_ADD, OP_SUB: begin
            res = full[DATA_W-1:0];
            c   = full[DATA_W];
            dc  = half[HALF];
         end
         OP_INC:  res = b + DATA_W'(1);
         OP_DEC:  res = b - DATA_W'(1);
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_COM:  res = ~b;
         OP_RL: begin
            res = {b[DATA_W-2:0], cin};
            c   = b[DATA_W-1];
         end
         OP_RR: begin
            res = {cin, b[DATA_W-1:1]};
            c   = b[0];
         end
         OP_SWAP: res = {b[HALF-1:0], b[DATA_W-1:HALF]};
         OP_BCLR: res = b & ~mask;
         OP_BSET: res = b | mask;
         default: res = '0;
      endcase
      z = (res == '0);
   end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] ld,
   input  logic [NFLAG-1:0] nxt,
   output logic [NFLAG-1:0] q
);

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         logic q_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (ld[i]) q_r <= nxt[i];
         end

         assign q[i] = q_r;

         // R12
         flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ld[i] |=> (q[i] == $past(q[i])));

         // R12
         flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld[i] |=> (q[i] == $past(nxt[i])));
      end
   endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int INSTR_W     = 12,
   parameter int DATA_W      = 8,
   parameter bit CARRY_CHAIN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  w_data,
   input  logic [DATA_W-1:0]  ram_data,
   input  logic [DATA_W-1:0]  sfr_data,
   input  logic               sfr_sel,
   output logic [DATA_W-1:0]  result,
   output logic               z_next,
   output logic               c_next,
   output logic               dc_next,
   output logic               z_load,
   output logic               c_load,
   output logic               dc_load,
   output logic               w_load,
   output logic               f_load,
   output logic               z_flag,
   output logic               c_flag,
   output logic               dc_flag
);

   localparam int LIT_W = 8;

   generate
      if (INSTR_W != 12) begin : g_bad_instr
         $error("acc_alu: INSTR_W must be 12");
      end
      if (DATA_W < 4 || DATA_W > LIT_W || (DATA_W % 2) != 0) begin : g_bad_data
         $error("acc_alu: DATA_W must be even and within 4..8");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] opnd_b;
   logic [NFLAG-1:0]  flag_q;

   acc_alu_decode u_dec (
      .fld (instr[11:5]),
      .dec (dec)
   );

   // R1: operand B mux, immediate overrides file sources
   assign opnd_b = dec.use_lit ? instr[DATA_W-1:0]
                 : (sfr_sel ? sfr_data : ram_data);

   acc_alu_core #(
      .DATA_W      (DATA_W),
      .CARRY_CHAIN (CARRY_CHAIN)
   ) u_core (
      .op      (dec.op),
      .a       (w_data),
      .b       (opnd_b),
      .cin     (c_flag),
      .bit_idx (instr[7:5]),
      .res     (result),
      .z       (z_next),
      .c       (c_next),
      .dc      (dc_next)
   );

   assign w_load  = dec.wr_w;
   assign f_load  = dec.wr_f;
   assign z_load  = dec.ld_z;
   assign c_load  = dec.ld_c;
   assign dc_load = dec.ld_dc;

   acc_alu_status #(.NFLAG(NFLAG)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    ({z_load, c_load, dc_load}),
      .nxt   ({z_next, c_next, dc_next}),
      .q     (flag_q)
   );

   assign z_flag  = flag_q[2];
   assign c_flag  = flag_q[1];
   assign dc_flag = flag_q[0];

   // R2
   dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({w_load, f_load}));

   // R2
   dest_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[11:10] == 2'b00 && !instr[5]) |-> !f_load);

   // R9
   lit_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[11:10] == 2'b11) |-> (w_load && !f_load && !c_load && !dc_load));

   // R6
   rot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[11:7] == 5'b00110) |-> (c_load && !z_load && !dc_load));

   // R11
   ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[11:9] == 3'b101 || instr[11:9] == 3'b011)
      |-> !(w_load || f_load || z_load || c_load || dc_load));

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

   typedef struct packed {
      logic [11:0] ins;
      logic [7:0]  w;
      logic [7:0]  ram;
      logic [7:0]  sfr;
      logic        sel;
      logic        cin;
      logic [7:0]  res;
      logic [4:0]  ld;   // {w, f, z, c, dc}
      logic [2:0]  fl;   // {z, c, dc}
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      '{12'h1E3, 8'h0F, 8'h01, 8'hEE, 1'b0, 1'b0, 8'h10, 5'b01111, 3'b001},
      '{12'h1C3, 8'h80, 8'h80, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10111, 3'b110},
      '{12'h1C3, 8'h01, 8'hEE, 8'hFE, 1'b1, 1'b1, 8'h00, 5'b10111, 3'b111},
      '{12'h083, 8'h01, 8'h05, 8'hEE, 1'b0, 1'b1, 8'h04, 5'b10111, 3'b011},
      '{12'h0A3, 8'h05, 8'h03, 8'hEE, 1'b0, 1'b1, 8'hFE, 5'b01111, 3'b000},
      '{12'h083, 8'h10, 8'h10, 8'hEE, 1'b0, 1'b0, 8'hFF, 5'b10111, 3'b000},
      '{12'h143, 8'hF0, 8'h0F, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10100, 3'b100},
      '{12'hD00, 8'h00, 8'hFF, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10100, 3'b100},
      '{12'hF5A, 8'hA5, 8'h00, 8'hEE, 1'b0, 1'b0, 8'hFF, 5'b10100, 3'b000},
      '{12'hC00, 8'h33, 8'hFF, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10000, 3'b000},
      '{12'h363, 8'h00, 8'h81, 8'hEE, 1'b0, 1'b0, 8'h02, 5'b01010, 3'b010},
      '{12'h303, 8'h00, 8'h01, 8'hEE, 1'b0, 1'b1, 8'h80, 5'b10010, 3'b010},
      '{12'h3A3, 8'h00, 8'h4B, 8'hEE, 1'b0, 1'b0, 8'hB4, 5'b01000, 3'b000},
      '{12'h2A3, 8'h00, 8'hFF, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b01100, 3'b100},
      '{12'h0C3, 8'h00, 8'hEE, 8'h01, 1'b1, 1'b0, 8'h00, 5'b10100, 3'b100},
      '{12'h243, 8'h00, 8'h5A, 8'hEE, 1'b0, 1'b0, 8'hA5, 5'b10100, 3'b000},
      '{12'h203, 8'h99, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10100, 3'b100},
      '{12'h023, 8'h77, 8'h12, 8'hEE, 1'b0, 1'b0, 8'h77, 5'b01000, 3'b000},
      '{12'h063, 8'h55, 8'h12, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b01100, 3'b100},
      '{12'h040, 8'h55, 8'h12, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b10100, 3'b100},
      '{12'h563, 8'h00, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h08, 5'b01000, 3'b000},
      '{12'h4E3, 8'h00, 8'hFF, 8'hEE, 1'b0, 1'b0, 8'h7F, 5'b01000, 3'b000},
      '{12'h2E3, 8'h00, 8'h01, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b01000, 3'b000},
      '{12'h3C3, 8'h00, 8'h10, 8'hEE, 1'b0, 1'b0, 8'h11, 5'b10000, 3'b000},
      '{12'hA12, 8'h3C, 8'h00, 8'hEE, 1'b0, 1'b1, 8'h00, 5'b00000, 3'b000},
      '{12'h6E3, 8'h3C, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b00000, 3'b000},
      '{12'h000, 8'h3C, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b00000, 3'b000},
      '{12'h006, 8'h3C, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b00000, 3'b000},
      '{12'h8AB, 8'h00, 8'h00, 8'hEE, 1'b0, 1'b0, 8'hAB, 5'b10000, 3'b000},
      '{12'h905, 8'h3C, 8'h00, 8'hEE, 1'b0, 1'b0, 8'h00, 5'b00000, 3'b000},
      '{12'h1C3, 8'h00, 8'h00, 8'h10, 1'b0, 1'b0, 8'h00, 5'b10111, 3'b100}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] instr = 12'h000;
   logic [7:0]  w_data = 8'h00;
   logic [7:0]  ram_data = 8'h00;
   logic [7:0]  sfr_data = 8'h00;
   logic        sfr_sel = 1'b0;
   logic [7:0]  result;
   logic        z_next, c_next, dc_next;
   logic        z_load, c_load, dc_load;
   logic        w_load, f_load;
   logic        z_flag, c_flag, dc_flag;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic z_m = 1'b0, c_m = 1'b0, dc_m = 1'b0;

   always #2 clk = ~clk;

   acc_alu uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .instr    (instr),
      .w_data   (w_data),
      .ram_data (ram_data),
      .sfr_data (sfr_data),
      .sfr_sel  (sfr_sel),
      .result   (result),
      .z_next   (z_next),
      .c_next   (c_next),
      .dc_next  (dc_next),
      .z_load   (z_load),
      .c_load   (c_load),
      .dc_load  (dc_load),
      .w_load   (w_load),
      .f_load   (f_load),
      .z_flag   (z_flag),
      .c_flag   (c_flag),
      .dc_flag  (dc_flag)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [11:0] ins);
      casez (ins[11:6])
         6'b000111:               return "R3";
         6'b000010:               return "R4";
         6'b00110?:               return "R6";
         6'b001110, 6'b001011,
         6'b001111:               return "R7";
         6'b01000?:               return "R8";
         6'b011???, 6'b1001??,
         6'b101???:               return "R11";
         6'b11????, 6'b1000??:    return "R9";
         6'b000001:               return "R10";
         6'b000000:               return ins[5] ? "R10" : "R11";
         default:                 return "R5";
      endcase
   endfunction

   // Force the stored carry through a rotate-right of {7'b0, c} (opcode 001100, d=0)
   task automatic set_carry(input logic c);
      @(negedge clk);
      instr    = 12'h303;
      ram_data = {7'b0, c};
      sfr_sel  = 1'b0;
      c_m      = c;
   endtask

   task automatic drive(input logic [11:0] ins, input logic [7:0] w,
                        input logic [7:0] r, input logic [7:0] s, input logic sel);
      instr = ins; w_data = w; ram_data = r; sfr_data = s; sfr_sel = sel;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: flags cleared by reset even while an add asks to load
      drive(12'h1C3, 8'hFF, 8'hFF, 8'h00, 1'b0);
      @(negedge clk);
      chk({z_flag, c_flag, dc_flag} == 3'b000, "R12", {z_flag, c_flag, dc_flag}, 3'b000);
      drive(12'h000, 8'h00, 8'h00, 8'h00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({z_flag, c_flag, dc_flag} == 3'b000, "R12", {z_flag, c_flag, dc_flag}, 3'b000);

      for (int i = 0; i < NV; i++) begin
         vec_t  v;
         string tag;
         v   = VEC[i];
         tag = req_of(v.ins);
         set_carry(v.cin);
         @(negedge clk);
         drive(v.ins, v.w, v.ram, v.sfr, v.sel);
         #1;
         if (v.ld[4] || v.ld[3])
            chk(result == v.res, tag, result, v.res);
         chk({w_load, f_load, z_load, c_load, dc_load} == v.ld, tag,
             {w_load, f_load, z_load, c_load, dc_load}, v.ld);
         chk(({z_next, c_next, dc_next} & v.ld[2:0]) == (v.fl & v.ld[2:0]), tag,
             {z_next, c_next, dc_next} & v.ld[2:0], v.fl & v.ld[2:0]);
         if (v.ld[2]) z_m  = v.fl[2];
         if (v.ld[1]) c_m  = v.fl[1];
         if (v.ld[0]) dc_m = v.fl[0];
         @(negedge clk);
         chk({z_flag, c_flag, dc_flag} == {z_m, c_m, dc_m}, "R12",
             {z_flag, c_flag, dc_flag}, {z_m, c_m, dc_m});
         instr = 12'h000;
      end

      // R1: move-from-file (opcode 001000, d=0) shows which source is used
      @(negedge clk);
      drive(12'h203, 8'h00, 8'h3C, 8'hC3, 1'b0);
      #1 chk(result == 8'h3C, "R1", result, 8'h3C);
      @(negedge clk);
      drive(12'h203, 8'h00, 8'h3C, 8'hC3, 1'b1);
      #1 chk(result == 8'hC3, "R1", result, 8'hC3);
      // R1: literal overrides both file sources
      drive(12'hC5A, 8'h00, 8'h3C, 8'hC3, 1'b1);
      #1 chk(result == 8'h5A, "R1", result, 8'h5A);

      // R2: increment (opcode 001010) with each destination bit
      drive(12'h283, 8'h00, 8'h01, 8'h00, 1'b0);
      #1 chk({w_load, f_load} == 2'b10, "R2", {w_load, f_load}, 2'b10);
      drive(12'h2A3, 8'h00, 8'h01, 8'h00, 1'b0);
      #1 chk({w_load, f_load} == 2'b01, "R2", {w_load, f_load}, 2'b01);
      instr = 12'h000;

      // R13: stored carry enters the adder: 0 + 0 + C
      set_carry(1'b1);
      @(negedge clk);
      drive(12'h1C3, 8'h00, 8'h00, 8'h00, 1'b0);
      #1 chk(result == 8'h01, "R13", result, 8'h01);
      set_carry(1'b0);
      @(negedge clk);
      drive(12'h1C3, 8'h00, 8'h00, 8'h00, 1'b0);
      #1 chk(result == 8'h00, "R13", result, 8'h00);
      // R13: rotate-left shifts stored carry into bit 0
      set_carry(1'b1);
      @(negedge clk);
      drive(12'h343, 8'h00, 8'h00, 8'h00, 1'b0);
      #1 chk(result == 8'h01, "R13", result, 8'h01);
      instr = 12'h000;

      // R12: asynchronous reset mid-run clears a set carry
      set_carry(1'b1);
      @(negedge clk);
      instr = 12'h000;
      chk(c_flag == 1'b1, "R12", c_flag, 1'b1);
      rst_n = 1'b0;
      #1 chk({z_flag, c_flag, dc_flag} == 3'b000, "R12", {z_flag, c_flag, dc_flag}, 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({z_flag, c_flag, dc_flag} == 3'b000, "R12", {z_flag, c_flag, dc_flag}, 3'b000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule